// File: doc/BRIEF.md
# Predetermining Six-Decade BCD Up/Down Counter

This block counts events on a single count input in six BCD decades, upward or downward, after an optional prescaler that divides the input by 5 or 6 or passes it through. Three BCD stores are supplied as inputs: a preset value, a presignal value and a main signal value. Two comparators raise flags when a count step lands on the presignal or main signal value, and a zero flag follows a count of 000000.

In automatic operation the counter closes its own cycle. Counting up, reaching the main value produces a short main pulse and then clears the count. Counting down, reaching zero produces a short zero pulse and then reloads the preset value. Each of the two automatic actions has its own inhibit input. When an action is inhibited, the counter instead stops and holds at the end value until the next step or an operator action. All inputs are synchronous to one clock. The count input is synchronized and edge-detected inside the block.

Top module: `bcd_predet_counter`

## Requirements
- R1: With `rst_n` low, or on any clock edge with `clr` high, the count becomes 000000, `presig_out` and `main_out` go low, the prescaler restarts and any pending automatic action is cancelled. `clr` takes priority over `load`.
- R2: A rising edge of `cnt_in` is counted once, however long the level is held. With divide-by-1 the count changes on the third rising clock edge after `cnt_in` is first sampled high.
- R3: The divide select chooses the prescaler. Code 2'b00 divides by 5, 2'b10 divides by 6, and 2'b11 and 2'b01 divide by 1. Under divide-by-N the count steps on the Nth detected input edge.
- R4: With `dir_up` = 1, a step adds one in BCD (4 bits per decade, least significant decade in bits 3:0) with carry across decades, and 999999 wraps to 000000.
- R5: With `dir_up` = 0, a step subtracts one in BCD with borrow, and 000000 wraps to 999999.
- R6: `load` high copies `preset_val` into the count, clears `presig_out` and cancels any pending automatic action. It leaves `main_out` unchanged.
- R7: `zero_out` is high exactly when the count is 000000.
- R8: `presig_out` goes high on a step that lands on `presig_val`. It stays high until a later step, `clr` or `load`.
- R9: With `hold_at_match` = 1, `main_out` goes high on a step that lands on `main_val`. It stays high, with the count held, until a later step or `clr`.
- R10: With `hold_at_match` = 0 and `dir_up` = 1, a step landing on `main_val` holds `main_out` high with the count at `main_val` for PULSE_CYC cycles. The count then becomes 000000 and `main_out` goes low.
- R11: With `hold_at_zero` = 0 and `dir_up` = 0, a step landing on 000000 keeps the count at zero (`zero_out` high) for PULSE_CYC cycles. The count then reloads from `preset_val`.
- R12: With `hold_at_zero` = 1 and counting down, the count stays at 000000 until `load` or a further step.
- R13: A step that arrives while an automatic action is pending is dropped. This includes the cycle in which the action completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 1 | Raw count input, asynchronous |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| div_sel | input | 2 | Prescaler select |
| clr | input | 1 | Synchronous clear of the counter |
| load | input | 1 | Load preset value into counter |
| hold_at_match | input | 1 | Inhibits automatic clear at main match |
| hold_at_zero | input | 1 | Inhibits automatic reload at zero |
| preset_val | input | 24 | Preset store, BCD |
| presig_val | input | 24 | Presignal store, BCD |
| main_val | input | 24 | Main signal store, BCD |
| count_bcd | output | 24 | Live count, BCD |
| presig_out | output | 1 | Presignal flag |
| main_out | output | 1 | Main signal flag |
| zero_out | output | 1 | Count-is-zero flag |

## Verification
Counting is tried with the following patterns:
- A load of 099999 followed by an up step separates a true decade carry from a binary increment.
- Steps from 999999 up and from 000000 down expose wrap errors.
- A down step from 100000 checks the chained borrow.
- Single short pulses, a long-held level, and pulse trains under each divide code separate edge detection from level sensing and show which prescaler ratio is in force.
- Both closing actions are run with the inhibits set and cleared, which tells the held flag apart from the timed pulse.
- A second input edge placed inside the automatic pulse window shows whether the pending action can be disturbed.

// File: rtl/bcd_predet_counter.sv
module bcd_predet_counter #(
  parameter int DIGITS    = 6,
  parameter int PULSE_CYC = 2,
  parameter int DIV_LO    = 5,
  parameter int DIV_HI    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_in,
  input  logic                  dir_up,
  input  logic [1:0]            div_sel,
  input  logic                  clr,
  input  logic                  load,
  input  logic                  hold_at_match,
  input  logic                  hold_at_zero,
  input  logic [4*DIGITS-1:0]   preset_val,
  input  logic [4*DIGITS-1:0]   presig_val,
  input  logic [4*DIGITS-1:0]   main_val,
  output logic [4*DIGITS-1:0]   count_bcd,
  output logic                  presig_out,
  output logic                  main_out,
  output logic                  zero_out
);
  localparam int W    = 4 * DIGITS;
  localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int PW   = $clog2(DMAX + 1);
  localparam int TW   = $clog2(PULSE_CYC + 1);

  function automatic logic [W-1:0] bcd_step(input logic [W-1:0] v, input logic up);
    logic [W-1:0] r;
    logic         c;
    logic [3:0]   d;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      d = v[4*i +: 4];
      if (c) begin
        if (up) begin
          if (d == 4'd9) r[4*i +: 4] = 4'd0;
          else begin r[4*i +: 4] = d + 4'd1; c = 1'b0; end
        end else begin
          if (d == 4'd0) r[4*i +: 4] = 4'd9;
          else begin r[4*i +: 4] = d - 4'd1; c = 1'b0; end
        end
      end
    end
    return r;
  endfunction

  logic [2:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] div_n;
  logic [W-1:0]  cnt_q;
  logic [W-1:0]  nxt;
  logic [TW-1:0] tmr_q;
  logic          pend_up_q;
  logic          presig_q;
  logic          main_q;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire last    = (pre_q >= div_n - PW'(1));
  wire step    = rise & last;
  wire busy    = (tmr_q != '0);
  wire expire  = (tmr_q == TW'(1));
  wire go      = step & ~busy;
  wire auto_up = go &  dir_up & ~hold_at_match & (nxt == main_val);
  wire auto_dn = go & ~dir_up & ~hold_at_zero  & (nxt == '0);

  always_comb begin
    case (div_sel)
      2'b00:   div_n = PW'(DIV_LO);
      2'b10:   div_n = PW'(DIV_HI);
      default: div_n = PW'(1);
    endcase
  end

  assign nxt = bcd_step(cnt_q, dir_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cnt_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (rise) pre_q <= last ? '0 : pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tmr_q     <= '0;
      pend_up_q <= 1'b0;
      presig_q  <= 1'b0;
      main_q    <= 1'b0;
    end else if (clr) begin
      cnt_q    <= '0;
      tmr_q    <= '0;
      presig_q <= 1'b0;
      main_q   <= 1'b0;
    end else if (load) begin
      cnt_q    <= preset_val;
      tmr_q    <= '0;
      presig_q <= 1'b0;
    end else if (busy) begin
      tmr_q <= tmr_q - TW'(1);
      if (expire) begin
        if (pend_up_q) begin
          cnt_q  <= '0;
          main_q <= 1'b0;
        end else begin
          cnt_q <= preset_val;
        end
      end
    end else if (go) begin
      cnt_q    <= nxt;
      presig_q <= (nxt == presig_val);
      main_q   <= (nxt == main_val);
      if (auto_up | auto_dn) begin
        tmr_q     <= TW'(PULSE_CYC);
        pend_up_q <= auto_up;
      end
    end
  end

  assign count_bcd  = cnt_q;
  assign presig_out = presig_q;
  assign main_out   = main_q;
  assign zero_out   = (cnt_q == '0);

  // R1
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_bcd == '0 && !presig_out && !main_out));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !clr && !load && !busy) |=> $stable(count_bcd));
  // R8
  presig_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(presig_out) |-> (count_bcd == $past(presig_val)));
  // R9
  main_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_out) |-> (count_bcd == $past(main_val)));
  // R10
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pend_up_q && !clr && !load) |=> (count_bcd == '0 && !main_out));
  // R11
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !pend_up_q && !clr && !load) |=> (count_bcd == $past(preset_val)));
  // R13
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && !clr && !load) |=> $stable(count_bcd));
endmodule

// File: tb/bcd_predet_counter_bench.sv
module bcd_predet_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_in = 1'b0;
  logic        dir_up = 1'b1;
  logic [1:0]  div_sel = 2'b11;
  logic        clr = 1'b0;
  logic        load = 1'b0;
  logic        hold_at_match = 1'b1;
  logic        hold_at_zero = 1'b1;
  logic [23:0] preset_val = 24'h000000;
  logic [23:0] presig_val = 24'h000003;
  logic [23:0] main_val = 24'h999998;
  logic [23:0] count_bcd;
  logic        presig_out, main_out, zero_out;

  bcd_predet_counter u_bcd_predet_counter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .dir_up(dir_up), .div_sel(div_sel),
    .clr(clr), .load(load), .hold_at_match(hold_at_match), .hold_at_zero(hold_at_zero),
    .preset_val(preset_val), .presig_val(presig_val), .main_val(main_val),
    .count_bcd(count_bcd), .presig_out(presig_out), .main_out(main_out), .zero_out(zero_out));

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [23:0] c;
    logic        p;
    logic        m;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input logic [23:0] c, input logic p, input logic m, input string tag);
    exp_t e;
    e.cyc = at; e.c = c; e.p = p; e.m = m; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        tests++;
        if (count_bcd !== q[i].c || zero_out !== (q[i].c == 24'h0) ||
            presig_out !== q[i].p || main_out !== q[i].m) begin
          fails++;
          $display("FAIL %s: cnt=%h z=%b p=%b m=%b expected cnt=%h z=%b p=%b m=%b",
                   q[i].tag, count_bcd, zero_out, presig_out, main_out,
                   q[i].c, (q[i].c == 24'h0), q[i].p, q[i].m);
        end
        q.delete(i);
      end
    end
  end

  task automatic settle(input logic [23:0] c, input logic p, input logic m, input string tag);
    push(cyc + 1, c, p, m, tag);
    @(negedge clk);
  endtask

  task automatic pulse_raw();
    cnt_in = 1'b1;
    @(negedge clk);
    cnt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic [23:0] c, input logic p, input logic m, input string tag);
    push(cyc + 3, c, p, m, tag);
    pulse_raw();
  endtask

  task automatic do_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_load(input logic [23:0] v);
    preset_val = v; load = 1'b1; @(negedge clk); load = 1'b0;
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(24'h0, 0, 0, "R1 R7 reset state");

    k = cyc;
    push(k + 2, 24'h0, 0, 0, "R2 not yet counted");
    push(k + 3, 24'h1, 0, 0, "R2 third-edge latency");
    pulse_raw();
    cnt_in = 1'b1; repeat (10) @(negedge clk); cnt_in = 1'b0; repeat (3) @(negedge clk);
    settle(24'h2, 0, 0, "R2 held level counts once");
    pulse(24'h3, 1, 0, "R8 presig set");
    settle(24'h3, 1, 0, "R8 presig holds");
    pulse(24'h4, 0, 0, "R8 presig cleared by step");

    do_clr(); div_sel = 2'b00;
    repeat (4) pulse_raw();
    settle(24'h0, 0, 0, "R3 div5 four edges");
    pulse(24'h1, 0, 0, "R3 div5 fifth edge");
    do_clr(); div_sel = 2'b10;
    repeat (5) pulse_raw();
    settle(24'h0, 0, 0, "R3 div6 five edges");
    pulse(24'h1, 0, 0, "R3 div6 sixth edge");
    do_clr(); div_sel = 2'b01;
    pulse(24'h1, 0, 0, "R3 code01 passes through");
    div_sel = 2'b11;

    do_load(24'h099999);
    settle(24'h099999, 0, 0, "R6 load preset");
    pulse(24'h100000, 0, 0, "R4 decade carry");
    do_load(24'h999999);
    pulse(24'h000000, 0, 0, "R4 R7 wrap up to zero");

    dir_up = 1'b0;
    do_load(24'h100000);
    pulse(24'h099999, 0, 0, "R5 decade borrow");
    do_load(24'h000001);
    pulse(24'h000000, 0, 0, "R12 manual reach zero");
    repeat (10) @(negedge clk);
    settle(24'h000000, 0, 0, "R12 holds at zero");
    pulse(24'h999999, 0, 0, "R5 wrap down");

    do_load(24'h000004);
    pulse(24'h000003, 1, 0, "R8 presig counting down");
    do_load(24'h000004);
    settle(24'h000004, 0, 0, "R6 load clears presig");

    dir_up = 1'b1; main_val = 24'h000012;
    do_load(24'h000011);
    pulse(24'h000012, 0, 1, "R9 manual main set");
    repeat (5) @(negedge clk);
    settle(24'h000012, 0, 1, "R9 main and count hold");
    pulse(24'h000013, 0, 0, "R9 main cleared by step");
    do_load(24'h000011);
    pulse(24'h000012, 0, 1, "R9 main set again");
    do_clr();
    settle(24'h0, 0, 0, "R1 clr clears main");

    hold_at_match = 1'b0;
    do_load(24'h000011);
    k = cyc;
    push(k + 3, 24'h000012, 0, 1, "R10 pulse first cycle");
    push(k + 4, 24'h000012, 0, 1, "R10 pulse second cycle");
    push(k + 5, 24'h000000, 0, 0, "R10 cleared after pulse");
    pulse_raw();
    settle(24'h0, 0, 0, "R10 stays cleared");

    dir_up = 1'b0; hold_at_zero = 1'b0; hold_at_match = 1'b1;
    do_load(24'h000001); preset_val = 24'h000050;
    k = cyc;
    push(k + 3, 24'h000000, 0, 0, "R11 R7 zero pulse first cycle");
    push(k + 4, 24'h000000, 0, 0, "R11 zero pulse second cycle");
    push(k + 5, 24'h000050, 0, 0, "R11 reload from preset");
    pulse_raw();
    settle(24'h000050, 0, 0, "R11 holds reload");

    do_load(24'h000001); preset_val = 24'h000050;
    k = cyc;
    push(k + 3, 24'h000000, 0, 0, "R13 zero reached");
    push(k + 5, 24'h000050, 0, 0, "R13 reload despite step");
    push(k + 7, 24'h000050, 0, 0, "R13 step dropped");
    cnt_in = 1'b1; @(negedge clk);
    cnt_in = 1'b0; @(negedge clk);
    cnt_in = 1'b1; @(negedge clk);
    cnt_in = 1'b0;
    repeat (6) @(negedge clk);

    if (q.size() != 0) begin
      fails += q.size();
      tests += q.size();
      $display("FAIL R1: %0d expected items never checked, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2: watchdog expired, cycle %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule